// File: doc/BRIEF.md
# Narrow-Port Target Write Assembler

This block sits behind a bus target controller that hands out write traffic over an 18-bit back-end port. Each cycle carries one 16-bit slice plus two tag bits. The block rebuilds a 64-bit command/address record and a run of 64-bit data beats, each beat with eight byte enables.

A phase counter walks the slices. It takes up to four address slices, least significant first, while the address enable is asserted. It then takes groups of four data slices while the write-data enable is asserted and the address enable is released. The address phase can stop early on the last-cycle input, and a data group can stop after its second slice.

When the address phase finishes, the block puts out the assembled address with its burst and dual-address flags and pulses a valid strobe for one cycle. When a data group finishes, it puts out the assembled data word and byte enables and pulses a second strobe. Lanes that never arrived read as zero. All three control inputs are active low, and reset is synchronous and active high.

Top module: `tw_assembler`

## Requirements
- R1: Synchronous reset, at any phase, returns the counter to idle and clears both strobes, the address record, the data word and the byte enables.
- R2: Address slices fill the address 16 bits at a time, least significant first: slice k of the word (bits 15:0) lands in address bits 16k+15:16k.
- R3: An address slice is taken only in a cycle where the address enable is low. In any other cycle of the address phase the counter, the address record and the address strobe stay unchanged.
- R4: The flags come from the first address slice. Word bit 17 is the burst flag and word bit 16 is the dual-address flag.
- R5: Last-cycle low on any address slice except the fourth ends the address phase at once. Address lanes not received read zero, so a two-slice address has its upper 32 bits at zero.
- R6: The address strobe is high for exactly the one cycle after the final address slice.
- R7: A data slice is taken only when the address enable is high and the write-data enable is low. In other cycles of the data phase the counter and the data word do not change.
- R8: Data slice k puts word bits 15:0 into data bits 16k+15:16k and word bits 17:16 into byte enables 2k+1:2k.
- R9: The data strobe is high for exactly the one cycle after the fourth slice of a group, or after the second slice when last-cycle is low with it. The unreceived lanes then carry zero data and zero byte enables.
- R10: After a fourth data slice without last-cycle, the next slices form a new data group with no new address phase. With last-cycle low on a group's final slice, the block returns to idle.
- R11: In idle, the write-data enable without the address enable has no effect: no strobe is raised and the held data word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_en_n | input | 1 | Address slice enable, active low |
| wdat_en_n | input | 1 | Write-data slice enable, active low |
| last_n | input | 1 | Last slice of the current phase, active low |
| wword | input | 18 | Tag bits 17:16 and slice bits 15:0 |
| hdr_valid | output | 1 | One-cycle strobe: address record complete |
| hdr_addr | output | 64 | Assembled address |
| hdr_burst | output | 1 | Burst flag of the record |
| hdr_dual | output | 1 | Dual-address flag of the record |
| beat_valid | output | 1 | One-cycle strobe: data beat complete |
| beat_data | output | 64 | Assembled data word |
| beat_be | output | 8 | Byte enables of the beat |

## Verification
The bench builds the block only with its default parameters: 16-bit slices, 2 tag bits and 4 lanes. This gives a three-bit phase counter in which lane 1 is the only short data exit and lane 3 always closes a group. At these values every exit of the counter is reachable: address phases of one, two and four slices, and data groups of two and four slices, both back to back and closing. Stalls in both phases, and stray enables in idle and during data, are driven between slices.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int TW_SLICE_W_DEF = 16;
   localparam int TW_TAG_W_DEF   = 2;
   localparam int TW_LANES_DEF   = 4;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_ADDR = 2'd1,
      ACT_DATA = 2'd2
   } act_e;
endpackage

// File: rtl/tw_phase_ctrl.sv
module tw_phase_ctrl
   import tw_pkg::*;
#(
   parameter int LANES = TW_LANES_DEF,
   localparam int LW = $clog2(LANES),
   localparam int PW = LW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          addr_en_n,
   input  logic          wdat_en_n,
   input  logic          last_n,
   output logic [PW-1:0] phase,
   output act_e          act,
   output logic          addr_done,
   output logic          data_done
);
   localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
   localparam logic [PW-1:0] DATA0     = {1'b1, {LW{1'b0}}};

   logic          in_data;
   logic [LW-1:0] lane;
   logic [PW-1:0] phase_d;

   assign in_data = phase[PW-1];
   assign lane    = phase[LW-1:0];

   always_comb begin
      if (!in_data && !addr_en_n)
         act = ACT_ADDR;
      else if (in_data && addr_en_n && !wdat_en_n)
         act = ACT_DATA;
      else
         act = ACT_NONE;
   end

   // address may stop on any lane; data may stop on odd lanes (32-bit boundary)
   assign addr_done = (act == ACT_ADDR) && ((lane == LAST_LANE) || !last_n);
   assign data_done = (act == ACT_DATA) && ((lane == LAST_LANE) || (lane[0] && !last_n));

   always_comb begin
      phase_d = phase;
      case (act)
         ACT_ADDR: phase_d = addr_done ? DATA0 : phase + PW'(1);
         ACT_DATA: begin
            if (data_done)
               phase_d = !last_n ? '0 : DATA0;
            else
               phase_d = phase + PW'(1);
         end
         default:  phase_d = phase;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase_d;
   end
endmodule

// File: rtl/tw_slice_gather.sv
module tw_slice_gather #(
   parameter int LANES   = 4,
   parameter int SLICE_W = 16,
   parameter int TAG_W   = 2,
   localparam int LW = $clog2(LANES)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [LW-1:0]            lane,
   input  logic [SLICE_W-1:0]       slice,
   input  logic [TAG_W-1:0]         tag,
   output logic [LANES*SLICE_W-1:0] bits,
   output logic [LANES*TAG_W-1:0]   tags
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SLICE_W-1:0] d_q;
      logic [TAG_W-1:0]   t_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            d_q <= '0;
            t_q <= '0;
         end else if (load && (lane == LW'(i))) begin
            d_q <= slice;
            t_q <= tag;
         end else if (load && (lane == '0)) begin
            // a fresh record starts: lanes not yet received read zero
            d_q <= '0;
            t_q <= '0;
         end
      end

      assign bits[i*SLICE_W +: SLICE_W] = d_q;
      assign tags[i*TAG_W +: TAG_W]     = t_q;
   end
endmodule

// File: rtl/tw_assembler.sv
module tw_assembler
   import tw_pkg::*;
#(
   parameter int SLICE_W = TW_SLICE_W_DEF,
   parameter int TAG_W   = TW_TAG_W_DEF,
   parameter int LANES   = TW_LANES_DEF,
   localparam int WORD_W = SLICE_W + TAG_W,
   localparam int LW     = $clog2(LANES),
   localparam int PW     = LW + 1,
   localparam int ADDR_W = LANES * SLICE_W,
   localparam int BE_W   = LANES * TAG_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_en_n,
   input  logic              wdat_en_n,
   input  logic              last_n,
   input  logic [WORD_W-1:0] wword,
   output logic              hdr_valid,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic              hdr_burst,
   output logic              hdr_dual,
   output logic              beat_valid,
   output logic [ADDR_W-1:0] beat_data,
   output logic [BE_W-1:0]   beat_be
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("tw_assembler: LANES must be a power of two of at least 2");
   end
   if (TAG_W < 2) begin : g_bad_tag
      $error("tw_assembler: TAG_W must hold the two address flags");
   end
   if (SLICE_W != 8 * TAG_W) begin : g_bad_slice
      $error("tw_assembler: one tag bit must cover one byte of a slice");
   end

   logic [PW-1:0]    phase;
   act_e             act;
   logic             addr_done;
   logic             data_done;
   logic [SLICE_W-1:0] slice;
   logic [TAG_W-1:0]   tag;
   logic [BE_W-1:0]    addr_tags;
   logic               unused_tags;

   assign slice = wword[SLICE_W-1:0];
   assign tag   = wword[WORD_W-1:SLICE_W];

   tw_phase_ctrl #(.LANES(LANES)) u_phase (
      .clk       (clk),
      .rst       (rst),
      .addr_en_n (addr_en_n),
      .wdat_en_n (wdat_en_n),
      .last_n    (last_n),
      .phase     (phase),
      .act       (act),
      .addr_done (addr_done),
      .data_done (data_done)
   );

   tw_slice_gather #(.LANES(LANES), .SLICE_W(SLICE_W), .TAG_W(TAG_W)) u_addr (
      .clk   (clk),
      .rst   (rst),
      .load  (act == ACT_ADDR),
      .lane  (phase[LW-1:0]),
      .slice (slice),
      .tag   (tag),
      .bits  (hdr_addr),
      .tags  (addr_tags)
   );

   tw_slice_gather #(.LANES(LANES), .SLICE_W(SLICE_W), .TAG_W(TAG_W)) u_data (
      .clk   (clk),
      .rst   (rst),
      .load  (act == ACT_DATA),
      .lane  (phase[LW-1:0]),
      .slice (slice),
      .tag   (tag),
      .bits  (beat_data),
      .tags  (beat_be)
   );

   // flags travel in the tag of the first address slice
   assign hdr_burst   = addr_tags[TAG_W-1];
   assign hdr_dual    = addr_tags[TAG_W-2];
   assign unused_tags = ^addr_tags;

   always_ff @(posedge clk) begin
      if (rst) begin
         hdr_valid  <= 1'b0;
         beat_valid <= 1'b0;
      end else begin
         hdr_valid  <= addr_done;
         beat_valid <= data_done;
      end
   end
endmodule

// File: rtl/tw_assembler_chk.sv
module tw_assembler_chk #(
   parameter int SLICE_W = 16,
   parameter int TAG_W   = 2,
   parameter int LANES   = 4,
   localparam int LW     = $clog2(LANES),
   localparam int PW     = LW + 1,
   localparam int ADDR_W = LANES * SLICE_W,
   localparam int BE_W   = LANES * TAG_W
) (
   input logic              clk,
   input logic              rst,
   input logic              addr_en_n,
   input logic              wdat_en_n,
   input logic              last_n,
   input logic [PW-1:0]     phase,
   input logic              hdr_valid,
   input logic [ADDR_W-1:0] hdr_addr,
   input logic              beat_valid,
   input logic [ADDR_W-1:0] beat_data,
   input logic [BE_W-1:0]   beat_be
);
   localparam logic [PW-1:0] DATA0 = {1'b1, {LW{1'b0}}};
   localparam logic [PW-1:0] DATA1 = {1'b1, LW'(1)};

   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> (!hdr_valid && !beat_valid && phase == '0));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!phase[PW-1] && addr_en_n) |=> ($stable(phase) && $stable(hdr_addr) && !hdr_valid));

   p_early_end_r5: assert property (@(posedge clk) disable iff (rst)
      (!phase[PW-1] && !addr_en_n && !last_n) |=> (phase == DATA0 && hdr_valid));

   p_hdr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      hdr_valid |=> !hdr_valid);

   p_data_gate_r7: assert property (@(posedge clk) disable iff (rst)
      (phase[PW-1] && (!addr_en_n || wdat_en_n)) |=> ($stable(phase) && $stable(beat_data) && !beat_valid));

   p_beat_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      beat_valid |=> !beat_valid);

   if (LANES > 2) begin : g_short
      p_short_be_r9: assert property (@(posedge clk) disable iff (rst)
         (phase == DATA1 && addr_en_n && !wdat_en_n && !last_n)
         |=> (beat_valid && beat_be[BE_W-1:2*TAG_W] == '0 && phase == '0));
   end

   p_idle_ignore_r11: assert property (@(posedge clk) disable iff (rst)
      (phase == '0 && addr_en_n) |=> (phase == '0 && !beat_valid && !hdr_valid && $stable(beat_data)));
endmodule

bind tw_assembler tw_assembler_chk #(
   .SLICE_W (SLICE_W),
   .TAG_W   (TAG_W),
   .LANES   (LANES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .addr_en_n  (addr_en_n),
   .wdat_en_n  (wdat_en_n),
   .last_n     (last_n),
   .phase      (phase),
   .hdr_valid  (hdr_valid),
   .hdr_addr   (hdr_addr),
   .beat_valid (beat_valid),
   .beat_data  (beat_data),
   .beat_be    (beat_be)
);

// File: tb/tb_tw_assembler.sv
module tb_tw_assembler;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        addr_en_n = 1'b1;
   logic        wdat_en_n = 1'b1;
   logic        last_n = 1'b1;
   logic [17:0] wword = '0;
   logic        hdr_valid, hdr_burst, hdr_dual, beat_valid;
   logic [63:0] hdr_addr, beat_data;
   logic [7:0]  beat_be;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tw_assembler dut (
      .clk(clk), .rst(rst), .addr_en_n(addr_en_n), .wdat_en_n(wdat_en_n),
      .last_n(last_n), .wword(wword), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
      .hdr_burst(hdr_burst), .hdr_dual(hdr_dual), .beat_valid(beat_valid),
      .beat_data(beat_data), .beat_be(beat_be)
   );

   // vector: [22]=addr_en_n [21]=wdat_en_n [20]=last_n [19:2]=word [1]=hdr_valid exp [0]=beat_valid exp
   function automatic logic [22:0] vec(bit an, bit wn, bit ln, logic [17:0] w, bit hv, bit bv);
      return {an, wn, ln, w, hv, bv};
   endfunction

   localparam int NV = 17;
   localparam logic [22:0] VECS [NV] = '{
      vec(1, 0, 1, 18'h3FFFF, 0, 0),  // R11 idle data-enable ignored
      vec(0, 1, 1, 18'h31111, 0, 0),
      vec(0, 1, 1, 18'h02222, 0, 0),
      vec(1, 1, 1, 18'h00000, 0, 0),  // R3 stall
      vec(0, 1, 1, 18'h03333, 0, 0),
      vec(0, 1, 1, 18'h04444, 1, 0),  // R6 fourth slice
      vec(1, 0, 1, 18'h35555, 0, 0),
      vec(1, 0, 1, 18'h36666, 0, 0),
      vec(1, 1, 1, 18'h00000, 0, 0),  // R7 gap
      vec(1, 0, 1, 18'h37777, 0, 0),
      vec(1, 0, 1, 18'h38888, 0, 1),  // R10 continue
      vec(1, 0, 1, 18'h19999, 0, 0),
      vec(1, 0, 0, 18'h2AAAA, 0, 1),  // R9 short group
      vec(1, 0, 1, 18'h3BBBB, 0, 0),  // R11
      vec(0, 1, 0, 18'h2CCCC, 1, 0),  // R5 one-slice address
      vec(1, 0, 1, 18'h3DDDD, 0, 0),
      vec(1, 0, 0, 18'h3EEEE, 0, 1)
   };

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(bit an, bit wn, bit ln, logic [17:0] w);
      addr_en_n = an;
      wdat_en_n = wn;
      last_n    = ln;
      wword     = w;
      @(posedge clk);
      #2;
   endtask

   task automatic idle_in();
      addr_en_n = 1'b1; wdat_en_n = 1'b1; last_n = 1'b1; wword = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 hdr_valid", 64'(hdr_valid), 64'd0);
      chk("R1 beat_valid", 64'(beat_valid), 64'd0);
      chk("R1 hdr_addr", hdr_addr, 64'd0);
      chk("R1 beat_be", 64'(beat_be), 64'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         step(VECS[i][22], VECS[i][21], VECS[i][20], VECS[i][19:2]);
         chk("R6 table hdr_valid", 64'(hdr_valid), 64'(VECS[i][1]));
         chk("R9/R10/R11 table beat_valid", 64'(beat_valid), 64'(VECS[i][0]));
      end
      chk("R5 one-slice address", hdr_addr, 64'h0000_0000_0000_CCCC);
      chk("R9 short beat data", beat_data, 64'h0000_0000_EEEE_DDDD);
      chk("R9 short beat be", 64'(beat_be), 64'h0F);
      idle_in();

      // R2 R3 R4: four-slice address with a stall carrying stray data-enable
      step(0, 1, 1, {2'b10, 16'hCDEF});
      step(1, 0, 1, {2'b11, 16'hFFFF});
      chk("R3 no strobe on stall", 64'(hdr_valid), 64'd0);
      step(0, 1, 1, {2'b01, 16'h89AB});
      step(0, 1, 1, {2'b00, 16'h4567});
      step(0, 1, 1, {2'b11, 16'h0123});
      chk("R6 strobe after fourth", 64'(hdr_valid), 64'd1);
      chk("R2 address", hdr_addr, 64'h0123_4567_89AB_CDEF);
      chk("R4 burst flag", 64'(hdr_burst), 64'd1);
      chk("R4 dual flag", 64'(hdr_dual), 64'd0);

      // R7 R8: full beat with an address-enable slice in the middle
      step(1, 0, 1, {2'b01, 16'h1111});
      step(0, 0, 1, {2'b11, 16'hDEAD});
      step(1, 0, 1, {2'b10, 16'h2222});
      step(1, 0, 1, {2'b11, 16'h3333});
      step(1, 0, 0, {2'b00, 16'h4444});
      chk("R9 full beat strobe", 64'(beat_valid), 64'd1);
      chk("R8 beat data", beat_data, 64'h4444_3333_2222_1111);
      chk("R8 beat be", 64'(beat_be), 64'h39);

      // R5: two-slice address, flags from the first slice
      step(0, 1, 1, {2'b01, 16'hAAAA});
      step(0, 1, 0, {2'b10, 16'hBBBB});
      chk("R5 early strobe", 64'(hdr_valid), 64'd1);
      chk("R5 upper zero", hdr_addr, 64'h0000_0000_BBBB_AAAA);
      chk("R4 dual from first", 64'(hdr_dual), 64'd1);
      chk("R4 burst from first", 64'(hdr_burst), 64'd0);

      // R9: two-slice beat clears the upper lanes of the previous full beat
      step(1, 0, 1, {2'b11, 16'h5555});
      step(1, 0, 0, {2'b11, 16'h6666});
      chk("R9 short strobe", 64'(beat_valid), 64'd1);
      chk("R9 short data", beat_data, 64'h0000_0000_6666_5555);
      chk("R9 short be", 64'(beat_be), 64'h0F);

      // R11: idle data-enables change nothing
      held = beat_data;
      for (int k = 0; k < 3; k++) begin
         step(1, 0, 1, {2'b11, 16'h7777});
         chk("R11 no beat in idle", 64'(beat_valid), 64'd0);
      end
      chk("R11 data held", beat_data, held);

      // R1: reset in the middle of an address phase
      step(0, 1, 1, {2'b11, 16'h1234});
      step(0, 1, 1, {2'b11, 16'h5678});
      rst = 1'b1;
      step(0, 1, 1, {2'b11, 16'h9ABC});
      rst = 1'b0;
      chk("R1 mid reset addr", hdr_addr, 64'd0);
      chk("R1 mid reset data", beat_data, 64'd0);
      chk("R1 mid reset be", 64'(beat_be), 64'd0);
      step(0, 1, 1, {2'b00, 16'h0004});
      step(0, 1, 1, {2'b00, 16'h0003});
      step(0, 1, 1, {2'b00, 16'h0002});
      step(0, 1, 1, {2'b00, 16'h0001});
      chk("R1 restart from idle", hdr_addr, 64'h0001_0002_0003_0004);
      chk("R6 restart strobe", 64'(hdr_valid), 64'd1);
      idle_in();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule